// File: doc/BRIEF.md
# Serial-Flash DMA Engine with Running Checksum

This block is the transfer engine of a serial-flash controller. It moves 32-bit words between the flash mapping window and system memory in either direction, or it only reads the flash and accumulates a checksum. Software uses that checksum to judge whether a candidate read-timing setting returns correct data. A running sum is kept in every mode, so a plain copy also yields a checksum of the data that was moved.

Software programs a flash address, a memory offset and a word count, then sets the enable bit in the control register. The memory-side address is the offset added to a base address fixed by a parameter. The engine moves one word per step. On a copy, each word takes one read handshake on the source side and one write handshake on the destination side. Completion sets a done flag. That flag raises an interrupt when interrupts are enabled, and it is cleared by writing one to it. For a calibration run, the control register also carries a serial clock divider and a read-delay count. These are driven out to the serial logic while the run is active.

Top module: `flash_dma`

## Requirements
- R1: After reset every register reads zero, `irq` is low and neither `fl_req` nor `mem_req` is asserted.
- R2: The flash address register (byte offset 0x08) and the memory offset register (0x0C) keep only bits [23:2]. The length register (0x10) keeps only bits [11:0]. All other bits read back as zero.
- R3: With control bit 1 clear and bit 2 clear, word i is read from flash byte address F+4i and written to memory address MEM_BASE+M+4i. With zero-wait responders, each word takes two cycles.
- R4: With control bit 1 set and bit 2 clear, word i is read from memory address MEM_BASE+M+4i and written to flash byte address F+4i.
- R5: With control bit 2 set (checksum mode), only flash reads are issued, with no memory request at all. With a zero-wait flash, each word takes one cycle.
- R6: The checksum register (0x14) holds the 32-bit wrapping sum of every word read during the run, in every mode. It is cleared when a run starts.
- R7: At the end of a run, the busy flag (status bit 1 at 0x04) falls and the done flag (status bit 0) rises in the same cycle. Writing 1 to status bit 0 clears done. `irq` is high exactly while done is set and control bit 12 is set.
- R8: A run started with length zero issues no request. It sets done one cycle after the start, and the checksum reads 0.
- R9: Writing the control register with bit 0 clear during a run stops the run at once. Busy clears, no further requests are issued, and done stays clear.
- R10: While a run with control bit 3 set is active, `cal_active` is high, `cal_clk_div` equals control bits [7:4] and `cal_delay` equals control bits [11:8]. At all other times these three outputs are zero.
- R11: A request that is not acknowledged stays asserted, with address and direction unchanged, until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| fl_req | output | 1 | Flash window access request |
| fl_we | output | 1 | Flash access is a write |
| fl_addr | output | 32 | Flash window byte address |
| fl_wdata | output | 32 | Flash write data |
| fl_ack | input | 1 | Flash access accepted |
| fl_rdata | input | 32 | Flash read data, valid with fl_ack |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access accepted |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| cal_active | output | 1 | Timing override in force |
| cal_clk_div | output | 4 | Override serial clock divider |
| cal_delay | output | 4 | Override read-delay cycle count |
| irq | output | 1 | Completion interrupt |

## Verification
Register reads are combinational, so a read gives the new value in the cycle after the write edge. Busy rises on the edge that takes the control write. With zero-wait responders, done replaces busy 2N edges later on a copy of N words, and N edges later in checksum mode. A zero-length run completes on the next edge. The bench drives on falling edges and counts falling edges after the start write. It samples busy one edge before the due cycle and done exactly at it, so both a slow and a fast completion are caught. The results of stalled runs and memory-to-flash runs have no fixed timing, so the bench polls until busy clears and then compares memory, flash and checksum.

// File: rtl/flash_dma.sv
module flash_dma #(
  parameter int          FA_W     = 24,
  parameter int          MA_W     = 24,
  parameter int          LEN_W    = 12,
  parameter logic [31:0] MEM_BASE = 32'h8000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        fl_req,
  output logic        fl_we,
  output logic [31:0] fl_addr,
  output logic [31:0] fl_wdata,
  input  logic        fl_ack,
  input  logic [31:0] fl_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        cal_active,
  output logic [3:0]  cal_clk_div,
  output logic [3:0]  cal_delay,
  output logic        irq
);

  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_FADR = 3'd2,
                         A_MADR = 3'd3, A_LEN  = 3'd4, A_SUM  = 3'd5;

  logic             dir_q, ck_q, cal_q, ie_q;
  logic [3:0]       div_q, dly_q;
  logic [FA_W-1:2]  fa_q, wfa;
  logic [MA_W-1:2]  ma_q, wma;
  logic [LEN_W-1:0] len_q, left;
  logic [31:0]      buf_q, sum_q;
  logic             busy_q, done_q, ph_q;

  wire [2:0] idx     = reg_addr[4:2];
  wire       wr_ctrl = reg_wr && idx == A_CTRL;
  wire       start   = wr_ctrl && reg_wdata[0] && !busy_q;
  wire       stop    = wr_ctrl && !reg_wdata[0] && busy_q;
  wire       unused_w = ^{reg_wdata, reg_addr[1:0]};

  wire to_flash  = dir_q && !ck_q;
  wire rd_ack    = !ph_q && (to_flash ? mem_ack : fl_ack);
  wire [31:0] rd_data = to_flash ? mem_rdata : fl_rdata;
  wire wr_ack    = ph_q && (to_flash ? fl_ack : mem_ack);
  wire step      = busy_q && (ck_q ? rd_ack : wr_ack);
  wire last      = left == LEN_W'(1);

  assign fl_req    = busy_q && (ph_q ? to_flash : !to_flash);
  assign fl_we     = busy_q && ph_q && to_flash;
  assign mem_req   = busy_q && (ph_q ? !to_flash : to_flash);
  assign mem_we    = busy_q && ph_q && !to_flash;
  assign fl_addr   = {{(32-FA_W){1'b0}}, wfa, 2'b00};
  assign mem_addr  = MEM_BASE + {{(32-MA_W){1'b0}}, wma, 2'b00};
  assign fl_wdata  = buf_q;
  assign mem_wdata = buf_q;

  assign cal_active  = busy_q && cal_q;
  assign cal_clk_div = cal_active ? div_q : 4'd0;
  assign cal_delay   = cal_active ? dly_q : 4'd0;
  assign irq         = done_q && ie_q;

  always_comb begin
    case (idx)
      A_CTRL:  reg_rdata = {19'd0, ie_q, dly_q, div_q, cal_q, ck_q, dir_q, busy_q};
      A_STAT:  reg_rdata = {30'd0, busy_q, done_q};
      A_FADR:  reg_rdata = {{(32-FA_W){1'b0}}, fa_q, 2'b00};
      A_MADR:  reg_rdata = {{(32-MA_W){1'b0}}, ma_q, 2'b00};
      A_LEN:   reg_rdata = {{(32-LEN_W){1'b0}}, len_q};
      A_SUM:   reg_rdata = sum_q;
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {dir_q, ck_q, cal_q, ie_q} <= '0;
      div_q <= '0;
      dly_q <= '0;
      fa_q  <= '0;
      ma_q  <= '0;
      len_q <= '0;
    end else if (reg_wr) begin
      if (idx == A_CTRL && (!busy_q || !reg_wdata[0])) begin
        dir_q <= reg_wdata[1];
        ck_q  <= reg_wdata[2];
        cal_q <= reg_wdata[3];
        div_q <= reg_wdata[7:4];
        dly_q <= reg_wdata[11:8];
        ie_q  <= reg_wdata[12];
      end
      if (idx == A_FADR) fa_q  <= reg_wdata[FA_W-1:2];
      if (idx == A_MADR) ma_q  <= reg_wdata[MA_W-1:2];
      if (idx == A_LEN)  len_q <= reg_wdata[LEN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ph_q   <= 1'b0;
      wfa    <= '0;
      wma    <= '0;
      left   <= '0;
      buf_q  <= '0;
      sum_q  <= '0;
    end else begin
      if (reg_wr && idx == A_STAT && reg_wdata[0]) done_q <= 1'b0;
      if (start) begin
        wfa   <= fa_q;
        wma   <= ma_q;
        left  <= len_q;
        sum_q <= '0;
        ph_q  <= 1'b0;
        if (len_q == '0) done_q <= 1'b1;
        else begin
          busy_q <= 1'b1;
          done_q <= 1'b0;
        end
      end else if (stop) begin
        busy_q <= 1'b0;
        ph_q   <= 1'b0;
      end else if (busy_q) begin
        if (rd_ack) begin
          sum_q <= sum_q + rd_data;
          buf_q <= rd_data;
          if (!ck_q) ph_q <= 1'b1;
        end
        if (step) begin
          wfa  <= wfa + 1'b1;
          wma  <= wma + 1'b1;
          left <= left - 1'b1;
          ph_q <= 1'b0;
          if (last) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/flash_dma_chk.sv
module flash_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fl_req,
  input logic        fl_ack,
  input logic        fl_we,
  input logic [31:0] fl_addr,
  input logic        mem_req,
  input logic        mem_ack,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic        busy,
  input logic        done,
  input logic        cal_active,
  input logic        irq
);

  p_fl_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req && !fl_ack |=> !busy || (fl_req && $stable(fl_addr) && $stable(fl_we)));

  p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> !busy || (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !fl_req && !mem_req);

  p_one_side_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_req && mem_req));

  p_busy_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_irq_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);

  p_cal_in_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cal_active |-> busy);

endmodule

bind flash_dma flash_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .fl_req(fl_req), .fl_ack(fl_ack), .fl_we(fl_we), .fl_addr(fl_addr),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we), .mem_addr(mem_addr),
  .busy(busy_q), .done(done_q), .cal_active(cal_active), .irq(irq)
);

// File: tb/tb_flash_dma.sv
`timescale 1ns/1ps
module tb_flash_dma;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic        reg_wr = 0;
  logic [4:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        fl_req, fl_we, fl_ack, mem_req, mem_we, mem_ack;
  logic [31:0] fl_addr, fl_wdata, fl_rdata, mem_addr, mem_wdata, mem_rdata;
  logic        cal_active, irq;
  logic [3:0]  cal_clk_div, cal_delay;
  logic        fl_stall = 0, mem_stall = 0;

  logic [31:0] flash_arr [0:63];
  logic [31:0] mem_arr   [0:63];
  int          mem_req_cnt = 0;
  int          n_chk = 0, n_fail = 0;

  flash_dma dut (.*);

  assign fl_ack    = fl_req && !fl_stall;
  assign fl_rdata  = flash_arr[fl_addr[7:2]];
  assign mem_ack   = mem_req && !mem_stall;
  assign mem_rdata = mem_arr[mem_addr[7:2]];

  always @(posedge clk) begin
    if (fl_req && fl_we && fl_ack) flash_arr[fl_addr[7:2]] <= fl_wdata;
    if (mem_req && mem_we && mem_ack) mem_arr[mem_addr[7:2]] <= mem_wdata;
    if (mem_req) mem_req_cnt <= mem_req_cnt + 1;
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 500; i++) begin
      rd(5'h04, s);
      if (!s[1]) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 6; a++) begin
      rd(5'(a*4), d);
      check("R1 register reset", d, 0);
    end
    check("R1 irq reset", irq, 0);
    check("R1 no request", {fl_req, mem_req}, 0);
  endtask

  task automatic t_masks();
    logic [31:0] d;
    wr(5'h08, 32'hFFFF_FFFF); rd(5'h08, d); check("R2 flash addr mask", d, 32'h00FF_FFFC);
    wr(5'h0C, 32'hFFFF_FFFF); rd(5'h0C, d); check("R2 mem addr mask", d, 32'h00FF_FFFC);
    wr(5'h10, 32'hFFFF_FFFF); rd(5'h10, d); check("R2 length mask", d, 32'h0000_0FFF);
  endtask

  task automatic t_f2m();
    logic [31:0] d, sum = 0;
    for (int i = 0; i < 5; i++) begin
      flash_arr[4+i] = 32'hF000_0000 + i * 32'h1111_1111;
      sum += flash_arr[4+i];
    end
    wr(5'h08, 32'h10); wr(5'h0C, 32'h20); wr(5'h10, 5);
    wr(5'h00, 32'h1001);
    repeat (9) @(negedge clk);
    rd(5'h04, d); check("R3 busy before last edge", d, 32'h2);
    @(negedge clk);
    rd(5'h04, d); check("R7 done after 2N cycles", d, 32'h1);
    check("R7 irq with enable", irq, 1);
    for (int i = 0; i < 5; i++) check("R3 copied word", mem_arr[8+i], flash_arr[4+i]);
    rd(5'h14, d); check("R6 checksum copy wraps", d, sum);
    wr(5'h04, 32'h1); rd(5'h04, d); check("R7 done cleared", d, 0);
    check("R7 irq cleared", irq, 0);
  endtask

  task automatic t_m2f();
    logic [31:0] d, sum = 0;
    for (int i = 0; i < 3; i++) begin
      mem_arr[20+i] = 32'h1234_0000 + i;
      sum += mem_arr[20+i];
    end
    wr(5'h08, 32'h80); wr(5'h0C, 32'h50); wr(5'h10, 3);
    wr(5'h00, 32'h3);
    wait_idle();
    for (int i = 0; i < 3; i++) check("R4 flash written", flash_arr[32+i], mem_arr[20+i]);
    rd(5'h14, d); check("R6 checksum m2f", d, sum);
    rd(5'h04, d); check("R7 done m2f", d, 32'h1);
    check("R7 irq masked", irq, 0);
    wr(5'h04, 32'h1);
  endtask

  task automatic t_cksum();
    logic [31:0] d, sum = 0;
    int base;
    for (int i = 0; i < 8; i++) begin
      flash_arr[i] = 32'h9000_0001 * (i + 3);
      sum += flash_arr[i];
    end
    wr(5'h08, 0); wr(5'h10, 8);
    base = mem_req_cnt;
    wr(5'h00, 32'h5);
    repeat (7) @(negedge clk);
    rd(5'h04, d); check("R5 busy before last", d, 32'h2);
    @(negedge clk);
    rd(5'h04, d); check("R5 done after N cycles", d, 32'h1);
    rd(5'h14, d); check("R6 checksum mode sum", d, sum);
    check("R5 no memory request", mem_req_cnt - base, 0);
    wr(5'h04, 32'h1);
  endtask

  task automatic t_zero();
    logic [31:0] d;
    wr(5'h10, 0);
    wr(5'h00, 32'h1);
    rd(5'h04, d); check("R8 zero length done", d, 32'h1);
    rd(5'h14, d); check("R8 zero length sum", d, 0);
    check("R8 no request", {fl_req, mem_req}, 0);
    wr(5'h04, 32'h1);
  endtask

  task automatic t_abort();
    logic [31:0] d;
    mem_arr[40] = 32'hDEAD_BEEF;
    mem_stall = 1;
    wr(5'h08, 0); wr(5'h0C, 32'hA0); wr(5'h10, 8);
    wr(5'h00, 32'h1001);
    repeat (4) @(negedge clk);
    rd(5'h04, d); check("R9 busy before abort", d, 32'h2);
    wr(5'h00, 32'h0);
    rd(5'h04, d); check("R9 abort clears busy no done", d, 0);
    check("R9 requests dropped", {fl_req, mem_req}, 0);
    check("R9 no irq", irq, 0);
    mem_stall = 0;
    repeat (3) @(negedge clk);
    check("R9 target untouched", mem_arr[40], 32'hDEAD_BEEF);
  endtask

  task automatic t_stall();
    flash_arr[16] = 32'hAAAA_0001; flash_arr[17] = 32'hBBBB_0002;
    fl_stall = 1;
    wr(5'h08, 32'h40); wr(5'h0C, 32'h60); wr(5'h10, 2);
    wr(5'h00, 32'h1);
    check("R11 request raised", fl_req, 1);
    repeat (3) @(negedge clk);
    check("R11 request held", fl_req, 1);
    check("R11 address held", fl_addr, 32'h40);
    fl_stall = 0;
    wait_idle();
    check("R11 word0 after stall", mem_arr[24], 32'hAAAA_0001);
    check("R11 word1 after stall", mem_arr[25], 32'hBBBB_0002);
    wr(5'h04, 32'h1);
  endtask

  task automatic t_cal();
    wr(5'h08, 0); wr(5'h10, 4);
    wr(5'h00, 32'h96D);
    check("R10 override active", cal_active, 1);
    check("R10 clock divider", cal_clk_div, 4'h6);
    check("R10 read delay", cal_delay, 4'h9);
    wait_idle();
    check("R10 released after run", {cal_active, cal_clk_div, cal_delay}, 0);
    wr(5'h04, 32'h1);
    wr(5'h00, 32'h965);
    check("R10 no override without flag", {cal_active, cal_clk_div, cal_delay}, 0);
    wait_idle();
    wr(5'h04, 32'h1);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      flash_arr[i] = 0;
      mem_arr[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_masks();
    t_f2m();
    t_m2f();
    t_cksum();
    t_zero();
    t_abort();
    t_stall();
    t_cal();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule